// File: doc/BRIEF.md
# Multichannel Phase Generator for Direct Digital Synthesis

This block produces the phase word that drives a sine/cosine lookup stage of a direct digital synthesizer. It serves several logical channels over time, one channel per valid input cycle, in fixed round-robin order. Each channel keeps its own accumulated phase. On its turn that phase advances by the channel's increment, modulo 2^N. The channel's offset is then added in a separate adder to form the output word. The output frequency of a channel is f_clk_ch · INC / 2^N, where f_clk_ch is the rate of that channel's turns. A new increment changes the frequency on the channel's next turn, with no settling, so the block can be used for frequency hopping.

The increment and the offset each have their own source, set by a parameter:
- **Fixed:** a parameter constant.
- **Programmable:** per-channel registers loaded through a configuration write port.
- **Streamed:** the value sampled on the input in the same cycle as the turn.

The output is a stream with a valid flag, a channel index and the phase word. It has no ready signal and accepts no back-pressure: a word appears one cycle after each valid input cycle, and the consumer must take it in that cycle. The configuration port is a plain write strobe.

Top module: `dds_phase_gen`

## Requirements
- R1: With `rst` high at a clock edge, every accumulated phase, every programmed increment and offset, and the round-robin pointer are cleared to zero, and after that edge `out_valid` is 0, `out_chan` is 0 and `out_phase` is 0.
- R2: `out_valid` is 1 exactly in the cycle after a cycle in which `in_valid` is 1 and `rst` is 0; otherwise it is 0.
- R3: Valid input cycles are assigned to channels 0, 1, ..., NUM_CH-1, then 0 again. The pointer holds during cycles with `in_valid` low. `out_chan` carries the index of the channel that was served.
- R4: On a channel's turn, its accumulated phase becomes (old phase + increment) mod 2^PHASE_W, and `out_phase` is (new phase + offset) mod 2^PHASE_W. After k turns with a constant increment INC and offset OFF, the output is (k·INC + OFF) mod 2^PHASE_W.
- R5: In programmable mode, a cycle with `cfg_we` = 1 stores `cfg_inc` and `cfg_off` for channel `cfg_ch`. A turn in the same cycle still uses the old values. Every later turn of that channel uses the new values. The write leaves the accumulated phase of every channel unchanged.
- R6: A channel's accumulated phase changes only on its own turn. Neither another channel's turn nor a configuration write moves it.
- R7: In streamed mode, the value on `in_inc` (or `in_off`) in the turn's cycle is used, and configuration writes to that quantity have no effect.
- R8: In fixed mode, the parameter constant is used, and both the configuration and the streamed value for that quantity have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks a sample cycle; one channel is served |
| in_inc | input | PHASE_W | Streamed increment (used in streamed increment mode) |
| in_off | input | PHASE_W | Streamed offset (used in streamed offset mode) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CH_W | Channel addressed by the write |
| cfg_inc | input | PHASE_W | Increment written (programmable mode) |
| cfg_off | input | PHASE_W | Offset written (programmable mode) |
| out_valid | output | 1 | Output word valid |
| out_chan | output | CH_W | Channel the output word belongs to |
| out_phase | output | PHASE_W | Offset-adjusted phase word |

## Verification
A corrupted accumulated phase does not show at once. It appears at the ports only on that channel's next turn, which comes NUM_CH valid cycles later. From then on it stays as a constant phase error, because the accumulator never resynchronises. A wrong round-robin pointer shows immediately as a wrong `out_chan`. It also shows as one channel's increment folded into another channel's phase. The bench therefore checks each channel over several turns, across stalls and across configuration writes, and compares against a model that tracks every channel separately.

// File: rtl/dds_pg_pkg.sv
package dds_pg_pkg;
  typedef enum logic [1:0] {
    SRC_FIXED  = 2'd0,
    SRC_PROG   = 2'd1,
    SRC_STREAM = 2'd2
  } src_mode_e;
endpackage

// File: rtl/dds_pg_source.sv
// Picks the increment or offset for the channel being served.
module dds_pg_source #(
  parameter int                    PHASE_W = 32,
  parameter int                    NUM_CH  = 4,
  parameter int                    CH_W    = 2,
  parameter dds_pg_pkg::src_mode_e MODE    = dds_pg_pkg::SRC_PROG,
  parameter logic [PHASE_W-1:0]    FIXED   = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [CH_W-1:0]    wch,
  input  logic [PHASE_W-1:0] wdata,
  input  logic [CH_W-1:0]    sel_ch,
  input  logic [PHASE_W-1:0] stream_val,
  output logic [PHASE_W-1:0] val
);
  if (MODE == dds_pg_pkg::SRC_PROG) begin : g_prog
    logic [PHASE_W-1:0] regs [NUM_CH];
    for (genvar i = 0; i < NUM_CH; i++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)                          regs[i] <= '0;
        else if (we && wch == CH_W'(i))   regs[i] <= wdata;
      end
      // R5: a channel's stored value moves only when that channel is written
      assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !(we && wch == CH_W'(i)) |=> $stable(regs[i]));
    end
    assign val = regs[sel_ch];
    logic unused_stream;
    assign unused_stream = ^stream_val;
  end else if (MODE == dds_pg_pkg::SRC_STREAM) begin : g_stream
    assign val = stream_val;
    logic unused_cfg;
    assign unused_cfg = ^{clk, rst, we, wch, wdata, sel_ch};
  end else begin : g_fixed
    assign val = FIXED;
    logic unused_all;
    assign unused_all = ^{clk, rst, we, wch, wdata, sel_ch, stream_val};
  end
endmodule

// File: rtl/dds_pg_accum.sv
// Round-robin channel pointer and per-channel phase accumulators.
module dds_pg_accum #(
  parameter int PHASE_W = 32,
  parameter int NUM_CH  = 4,
  parameter int CH_W    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  logic [PHASE_W-1:0] inc,
  output logic [CH_W-1:0]    ch_ptr,
  output logic [PHASE_W-1:0] acc_next
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  logic [PHASE_W-1:0] acc_q [NUM_CH];

  assign acc_next = acc_q[ch_ptr] + inc;

  always_ff @(posedge clk) begin
    if (rst)                   ch_ptr <= '0;
    else if (step)             ch_ptr <= (ch_ptr == LAST_CH) ? '0 : ch_ptr + 1'b1;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)                                acc_q[i] <= '0;
      else if (step && ch_ptr == CH_W'(i))    acc_q[i] <= acc_next;
    end
    // R6: only the channel's own turn may move its phase
    assert_chan_isolated_R6: assert property (@(posedge clk) disable iff (rst)
      !(step && ch_ptr == CH_W'(i)) |=> $stable(acc_q[i]));
  end

  // R3: pointer holds on idle cycles and stays in range
  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(ch_ptr));
  assert_ptr_range_R3: assert property (@(posedge clk) disable iff (rst)
    ch_ptr <= LAST_CH);
endmodule

// File: rtl/dds_phase_gen.sv
module dds_phase_gen #(
  parameter int                    PHASE_W   = 32,
  parameter int                    NUM_CH    = 4,
  parameter dds_pg_pkg::src_mode_e INC_SRC   = dds_pg_pkg::SRC_PROG,
  parameter dds_pg_pkg::src_mode_e OFF_SRC   = dds_pg_pkg::SRC_PROG,
  parameter logic [PHASE_W-1:0]    FIXED_INC = PHASE_W'(1),
  parameter logic [PHASE_W-1:0]    FIXED_OFF = '0,
  localparam int                   CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [PHASE_W-1:0] in_inc,
  input  logic [PHASE_W-1:0] in_off,
  input  logic               cfg_we,
  input  logic [CH_W-1:0]    cfg_ch,
  input  logic [PHASE_W-1:0] cfg_inc,
  input  logic [PHASE_W-1:0] cfg_off,
  output logic               out_valid,
  output logic [CH_W-1:0]    out_chan,
  output logic [PHASE_W-1:0] out_phase
);
  logic [CH_W-1:0]    ch_ptr;
  logic [PHASE_W-1:0] inc_sel, off_sel, acc_next;

  dds_pg_source #(.PHASE_W(PHASE_W), .NUM_CH(NUM_CH), .CH_W(CH_W),
                  .MODE(INC_SRC), .FIXED(FIXED_INC)) u_inc_src (
    .clk(clk), .rst(rst), .we(cfg_we), .wch(cfg_ch), .wdata(cfg_inc),
    .sel_ch(ch_ptr), .stream_val(in_inc), .val(inc_sel));

  dds_pg_source #(.PHASE_W(PHASE_W), .NUM_CH(NUM_CH), .CH_W(CH_W),
                  .MODE(OFF_SRC), .FIXED(FIXED_OFF)) u_off_src (
    .clk(clk), .rst(rst), .we(cfg_we), .wch(cfg_ch), .wdata(cfg_off),
    .sel_ch(ch_ptr), .stream_val(in_off), .val(off_sel));

  dds_pg_accum #(.PHASE_W(PHASE_W), .NUM_CH(NUM_CH), .CH_W(CH_W)) u_accum (
    .clk(clk), .rst(rst), .step(in_valid), .inc(inc_sel),
    .ch_ptr(ch_ptr), .acc_next(acc_next));

  // Offset adder sits outside the accumulator loop, then one output register.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_phase <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_chan  <= ch_ptr;
        out_phase <= acc_next + off_sel;
      end
    end
  end

  // R1: reset leaves a quiet output
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_chan == '0 && out_phase == '0));
  // R2: one-cycle latency, no output without an input
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R3: output tag carries the served channel
  assert_tag_matches_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_chan == $past(ch_ptr));
endmodule

// File: tb/test_dds_phase_gen.sv
module test_dds_phase_gen;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] B_OFF = 32'h4000_0000;

  // {increment, offset, expected output on third turn}
  localparam logic [31:0] VEC [4][3] = '{
    '{32'h0000_0100, 32'h0000_0000, 32'h0000_0300},
    '{32'h4000_0000, 32'h1000_0000, 32'hD000_0000},
    '{32'h8000_0001, 32'hFFFF_FFFF, 32'h8000_0002},
    '{32'hFFFF_FFFF, 32'h0000_0010, 32'h0000_000D}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  // instance A: programmable increment and offset, 4 channels
  logic        a_valid = 0, a_we = 0;
  logic [1:0]  a_cfg_ch = 0;
  logic [31:0] a_cfg_inc = 0, a_cfg_off = 0, a_s_inc = 0, a_s_off = 0;
  logic        a_ov;
  logic [1:0]  a_och;
  logic [31:0] a_oph;

  dds_phase_gen i_dds_phase_gen (
    .clk(clk), .rst(rst), .in_valid(a_valid), .in_inc(a_s_inc), .in_off(a_s_off),
    .cfg_we(a_we), .cfg_ch(a_cfg_ch), .cfg_inc(a_cfg_inc), .cfg_off(a_cfg_off),
    .out_valid(a_ov), .out_chan(a_och), .out_phase(a_oph));

  // instance B: streamed increment, fixed offset, 2 channels
  logic        b_valid = 0, b_we = 0;
  logic [0:0]  b_cfg_ch = 0;
  logic [31:0] b_cfg_inc = 0, b_cfg_off = 0, b_s_inc = 0, b_s_off = 0;
  logic        b_ov;
  logic [0:0]  b_och;
  logic [31:0] b_oph;

  dds_phase_gen #(.NUM_CH(2), .INC_SRC(dds_pg_pkg::SRC_STREAM),
                  .OFF_SRC(dds_pg_pkg::SRC_FIXED), .FIXED_OFF(B_OFF)) i_dds_phase_gen_b (
    .clk(clk), .rst(rst), .in_valid(b_valid), .in_inc(b_s_inc), .in_off(b_s_off),
    .cfg_we(b_we), .cfg_ch(b_cfg_ch), .cfg_inc(b_cfg_inc), .cfg_off(b_cfg_off),
    .out_valid(b_ov), .out_chan(b_och), .out_phase(b_oph));

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_acc [4], m_inc [4], m_off [4];
  int m_ptr = 0;
  logic [31:0] mb_acc [2];
  int mb_ptr = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_a_reset();
    for (int i = 0; i < 4; i++) begin m_acc[i] = 0; m_inc[i] = 0; m_off[i] = 0; end
    m_ptr = 0;
  endtask

  // one cycle on instance A; inputs applied away from the edge, outputs read after it
  task automatic drive_a(input logic v, input logic we, input int ch,
                         input logic [31:0] inc, input logic [31:0] off,
                         input string req, output logic [31:0] got);
    logic [31:0] e_ph;
    int e_ch;
    e_ph = 0; e_ch = 0;
    a_valid = v; a_we = we; a_cfg_ch = ch[1:0]; a_cfg_inc = inc; a_cfg_off = off;
    if (v) begin
      e_ch = m_ptr;
      m_acc[m_ptr] = m_acc[m_ptr] + m_inc[m_ptr];
      e_ph = m_acc[m_ptr] + m_off[m_ptr];
      m_ptr = (m_ptr + 1) % 4;
    end
    if (we) begin m_inc[ch] = inc; m_off[ch] = off; end
    @(posedge clk); #1;
    a_valid = 0; a_we = 0;
    got = a_oph;
    check("R2 out_valid", 32'(a_ov), 32'(v));
    if (v) begin
      check("R3 out_chan", 32'(a_och), 32'(e_ch));
      check(req, a_oph, e_ph);
    end
  endtask

  task automatic drive_b(input logic v, input logic [31:0] sinc, input logic we,
                         input logic [31:0] junk, input string req);
    logic [31:0] e_ph;
    int e_ch;
    e_ph = 0; e_ch = 0;
    b_valid = v; b_s_inc = sinc; b_we = we; b_cfg_ch = mb_ptr[0:0];
    b_cfg_inc = junk; b_cfg_off = junk; b_s_off = ~junk;
    if (v) begin
      e_ch = mb_ptr;
      mb_acc[mb_ptr] = mb_acc[mb_ptr] + sinc;
      e_ph = mb_acc[mb_ptr] + B_OFF;
      mb_ptr = (mb_ptr + 1) % 2;
    end
    @(posedge clk); #1;
    b_valid = 0; b_we = 0;
    check("R2 B out_valid", 32'(b_ov), 32'(v));
    if (v) begin
      check("R3 B out_chan", 32'(b_och), 32'(e_ch));
      check(req, b_oph, e_ph);
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] got;
    model_a_reset();
    mb_acc[0] = 0; mb_acc[1] = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1: reset state
    check("R1 out_valid", 32'(a_ov), 0);
    check("R1 out_chan", 32'(a_och), 0);
    check("R1 out_phase", a_oph, 0);

    // program all channels from the table; no output without valid (R2)
    for (int c = 0; c < 4; c++)
      drive_a(0, 1, c, VEC[c][0], VEC[c][1], "R5", got);

    // R4: three turns per channel, third turn against the table
    for (int t = 0; t < 12; t++) begin
      drive_a(1, 0, 0, 0, 0, "R4 phase", got);
      if (t >= 8) check("R4 table k=3", got, VEC[t-8][2]);
    end

    // R3: stall keeps the pointer; next turn is channel 0 again
    drive_a(0, 0, 0, 0, 0, "R3", got);
    drive_a(0, 0, 0, 0, 0, "R3", got);
    drive_a(1, 0, 0, 0, 0, "R3 after stall", got);

    // R5: write channel 1 in the cycle it is served: old values on this turn
    drive_a(1, 1, 1, 32'h0000_0005, 32'h0000_0007, "R5 same-cycle old", got);
    // R5/R6: write channel 3 while channel 2 is served; channel 3 phase kept
    drive_a(1, 1, 3, 32'h0000_1000, 32'h0000_0000, "R6 other turn", got);
    for (int t = 0; t < 8; t++)
      drive_a(1, 0, 0, 0, 0, "R5 new values", got);

    // R1: reset mid-run clears phase and programmed values
    rst = 1;
    a_valid = 1;
    @(posedge clk); #1;
    rst = 0; a_valid = 0;
    check("R1 mid-run out_valid", 32'(a_ov), 0);
    model_a_reset();
    mb_acc[0] = 0; mb_acc[1] = 0; mb_ptr = 0;
    for (int t = 0; t < 4; t++)
      drive_a(1, 0, 0, 0, 0, "R1 cleared config", got);

    // R7/R8: streamed increment, fixed offset; config and streamed offset ignored
    drive_b(1, 32'h0000_000A, 1, 32'h1234_5678, "R7 stream inc");
    drive_b(1, 32'h0000_0014, 1, 32'hDEAD_BEEF, "R8 fixed off");
    drive_b(0, 32'hFFFF_0000, 1, 32'h5555_5555, "R7 idle");
    drive_b(1, 32'hFFFF_FFFF, 0, 32'h0, "R7 wrap");
    drive_b(1, 32'h8000_0000, 1, 32'hAAAA_AAAA, "R8 fixed off");
    drive_b(1, 32'h0000_0001, 0, 32'h0, "R7 stream inc");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule